// File: doc/BRIEF.md
# Age-Ordered Issue Queue

This block is the scheduling window of an out-of-order core. Dispatch writes one instruction per cycle into a free slot. Each instruction carries a sequence number, a two-bit operation class, up to two source registers and an optional destination register. A source is ready either because a one-bit-per-register readiness table already marks it as produced, or because a completion broadcast names its register tag. When every source of an entry is ready, the entry joins the ready set of its class. Each cycle the queue offers up to `ISSUE_W` instructions: it compares the oldest ready entry of every class and takes the oldest of those first.

Register operands are given as a kind bit (integer or floating point) and an index. The block maps them into one flat tag space in which the integer registers come first and the floating-point registers follow straight after. An entry marked as must-not-run-speculatively waits, even with all sources ready, until a release input names its sequence number. An issued entry keeps its slot until a commit or a squash frees it. Commit frees every entry at or older than a given sequence number. Squash frees every entry strictly younger than one.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt` equals `DEPTH` (16), `full` is 0, no issue slot is valid, and every register is marked ready in the readiness table.
- R2: An inserted entry whose sources are all ready is offered in issue slot 0 in the cycle after its insertion edge, is offered only once, and keeps its slot (`free_cnt` unchanged) after it issues.
- R3: At most `ISSUE_W` (2) entries are offered per cycle, chosen oldest first across all classes. Slot 0 holds the oldest, slot k is valid only if slot k-1 is, and `issue_cls` reports each entry's class.
- R4: Age uses 6-bit wrapping sequence numbers: a is older than b when bit 5 of (a - b) mod 64 is set, so 62 and 63 are older than 0 and 1.
- R5: Integer index i maps to flat tag i and floating-point index j maps to tag `INT_REGS` + j (`INT_REGS` = 40). `issue_dst` reports the flat tag of the destination, and a source waits only on its own flat tag.
- R6: Inserting an entry with a destination clears that tag's ready bit. A completion broadcast sets the bit and makes every waiting source with that tag ready at the same edge.
- R7: When a broadcast and an insertion whose source has the broadcast tag fall in the same cycle, the new entry is ready and issues in the next cycle.
- R8: A non-speculative entry never issues on operand readiness alone. It issues in the cycle after a release input carries its exact sequence number.
- R9: Commit frees every valid entry whose sequence number is at or older than `commit_seq`, that one included.
- R10: Squash frees every valid entry strictly younger than `squash_seq` and leaves that entry and older ones in place.
- R11: `free_cnt` counts empty slots and `full` is 1 exactly when it is 0. An insertion while full is ignored: it takes no slot and never issues. `free_cnt` drops by at most 1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_cls | input | CLS_W | Operation class |
| ins_s0_use | input | 1 | Source 0 present |
| ins_s0_fp | input | 1 | Source 0 is floating point |
| ins_s0_idx | input | IDX_W | Source 0 index within its kind |
| ins_s1_use | input | 1 | Source 1 present |
| ins_s1_fp | input | 1 | Source 1 is floating point |
| ins_s1_idx | input | IDX_W | Source 1 index within its kind |
| ins_d_use | input | 1 | Destination present |
| ins_d_fp | input | 1 | Destination is floating point |
| ins_d_idx | input | IDX_W | Destination index within its kind |
| ins_nonspec | input | 1 | Hold until released by sequence number |
| wake_valid | input | 1 | Completion broadcast |
| wake_fp | input | 1 | Broadcast register is floating point |
| wake_idx | input | IDX_W | Broadcast register index |
| rel_valid | input | 1 | Release of a non-speculative entry |
| rel_seq | input | SEQ_W | Sequence number being released |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest sequence number committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| issue_vld | output | ISSUE_W | Per-slot issue valid |
| issue_seq | output | ISSUE_W*SEQ_W | Per-slot sequence number, slot k at bits k*SEQ_W |
| issue_cls | output | ISSUE_W*CLS_W | Per-slot class |
| issue_dst | output | ISSUE_W*TAG_W | Per-slot flat destination tag |
| free_cnt | output | CNT_W | Number of empty slots |
| full | output | 1 | No empty slot |

## Verification
Every state change happens on a rising edge. The issue outputs depend only on registered state: an entry inserted ready, woken by a broadcast, or released is offered in the cycle right after that edge, and it is gone one cycle later. `free_cnt` and `full` reflect an insertion, commit or squash in the cycle after the edge that carried it. The bench drives inputs 1 ns after a rising edge and lets exactly one edge pass per step. It reads the outputs 1 ns after that edge, before it drives anything new, so every check lands in the cycle in which its result is due. Multi-cycle orderings, such as pairs leaving in age order, are checked step by step against sequence lists fixed in the bench.

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int DEPTH    = 16,
  parameter int SEQ_W    = 6,
  parameter int CLS_W    = 2,
  parameter int INT_REGS = 40,
  parameter int FP_REGS  = 24,
  parameter int ISSUE_W  = 2,
  localparam int NCLS    = 1 << CLS_W,
  localparam int PREGS   = INT_REGS + FP_REGS,
  localparam int TAG_W   = $clog2(PREGS),
  localparam int IDX_W   = $clog2(INT_REGS > FP_REGS ? INT_REGS : FP_REGS),
  localparam int SLOT_W  = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_valid,
  input  logic [SEQ_W-1:0]           ins_seq,
  input  logic [CLS_W-1:0]           ins_cls,
  input  logic                       ins_s0_use,
  input  logic                       ins_s0_fp,
  input  logic [IDX_W-1:0]           ins_s0_idx,
  input  logic                       ins_s1_use,
  input  logic                       ins_s1_fp,
  input  logic [IDX_W-1:0]           ins_s1_idx,
  input  logic                       ins_d_use,
  input  logic                       ins_d_fp,
  input  logic [IDX_W-1:0]           ins_d_idx,
  input  logic                       ins_nonspec,
  input  logic                       wake_valid,
  input  logic                       wake_fp,
  input  logic [IDX_W-1:0]           wake_idx,
  input  logic                       rel_valid,
  input  logic [SEQ_W-1:0]           rel_seq,
  input  logic                       commit_valid,
  input  logic [SEQ_W-1:0]           commit_seq,
  input  logic                       squash_valid,
  input  logic [SEQ_W-1:0]           squash_seq,
  output logic [ISSUE_W-1:0]         issue_vld,
  output logic [ISSUE_W*SEQ_W-1:0]   issue_seq,
  output logic [ISSUE_W*CLS_W-1:0]   issue_cls,
  output logic [ISSUE_W*TAG_W-1:0]   issue_dst,
  output logic [CNT_W-1:0]           free_cnt,
  output logic                       full
);

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic logic [TAG_W-1:0] flat(input logic fp, input logic [IDX_W-1:0] idx);
    return fp ? TAG_W'(INT_REGS) + TAG_W'(idx) : TAG_W'(idx);
  endfunction

  logic [DEPTH-1:0] vld, iss, nsp, rel, r0, r1;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [CLS_W-1:0] cls_q [DEPTH];
  logic [TAG_W-1:0] t0_q  [DEPTH];
  logic [TAG_W-1:0] t1_q  [DEPTH];
  logic [TAG_W-1:0] dst_q [DEPTH];
  logic [PREGS-1:0] sb;

  logic [TAG_W-1:0] s0_tag, s1_tag, d_tag, w_tag;
  assign s0_tag = flat(ins_s0_fp, ins_s0_idx);
  assign s1_tag = flat(ins_s1_fp, ins_s1_idx);
  assign d_tag  = flat(ins_d_fp, ins_d_idx);
  assign w_tag  = flat(wake_fp, wake_idx);

  logic s0_ok, s1_ok;
  assign s0_ok = !ins_s0_use || sb[s0_tag] || (wake_valid && w_tag == s0_tag);
  assign s1_ok = !ins_s1_use || sb[s1_tag] || (wake_valid && w_tag == s1_tag);

  logic [DEPTH-1:0] rdy;
  assign rdy = vld & ~iss & r0 & r1 & (~nsp | rel);

  logic [SLOT_W-1:0] slot;
  always_comb begin
    slot = '0;
    free_cnt = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) slot = SLOT_W'(i);
      free_cnt = free_cnt + CNT_W'(!vld[i]);
    end
  end

  assign full = (free_cnt == '0);

  logic ins_fire;
  assign ins_fire = ins_valid && !full;

  logic [DEPTH-1:0]  pick;
  logic [SLOT_W-1:0] sel_i [ISSUE_W];

  always_comb begin
    logic [NCLS-1:0]   hv;
    logic [SLOT_W-1:0] hi [NCLS];
    logic              bv;
    logic [SLOT_W-1:0] bi;
    pick = '0;
    issue_vld = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      hv = '0;
      for (int c = 0; c < NCLS; c++) begin
        hi[c] = '0;
        for (int i = 0; i < DEPTH; i++)
          if (rdy[i] && !pick[i] && cls_q[i] == CLS_W'(c) &&
              (!hv[c] || older(seq_q[i], seq_q[hi[c]]))) begin
            hv[c] = 1'b1;
            hi[c] = SLOT_W'(i);
          end
      end
      bv = 1'b0;
      bi = '0;
      for (int c = 0; c < NCLS; c++)
        if (hv[c] && (!bv || older(seq_q[hi[c]], seq_q[bi]))) begin
          bv = 1'b1;
          bi = hi[c];
        end
      sel_i[k] = bi;
      issue_vld[k] = bv;
      if (bv) pick[bi] = 1'b1;
    end
  end

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
    assign issue_seq[k*SEQ_W +: SEQ_W] = seq_q[sel_i[k]];
    assign issue_cls[k*CLS_W +: CLS_W] = cls_q[sel_i[k]];
    assign issue_dst[k*TAG_W +: TAG_W] = dst_q[sel_i[k]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; iss <= '0; nsp <= '0; rel <= '0; r0 <= '0; r1 <= '0;
      sb  <= '1;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i] <= '0; cls_q[i] <= '0; t0_q[i] <= '0; t1_q[i] <= '0; dst_q[i] <= '0;
      end
    end else begin
      if (wake_valid) sb[w_tag] <= 1'b1;
      if (ins_fire && ins_d_use) sb[d_tag] <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (wake_valid && t0_q[i] == w_tag) r0[i] <= 1'b1;
        if (wake_valid && t1_q[i] == w_tag) r1[i] <= 1'b1;
        if (rel_valid && nsp[i] && seq_q[i] == rel_seq) rel[i] <= 1'b1;
        if (pick[i]) iss[i] <= 1'b1;
        if (vld[i] && ((commit_valid && !older(commit_seq, seq_q[i])) ||
                       (squash_valid && older(squash_seq, seq_q[i]))))
          vld[i] <= 1'b0;
      end
      if (ins_fire) begin
        vld[slot]   <= 1'b1;
        iss[slot]   <= 1'b0;
        rel[slot]   <= 1'b0;
        nsp[slot]   <= ins_nonspec;
        r0[slot]    <= s0_ok;
        r1[slot]    <= s1_ok;
        seq_q[slot] <= ins_seq;
        cls_q[slot] <= ins_cls;
        t0_q[slot]  <= s0_tag;
        t1_q[slot]  <= s1_tag;
        dst_q[slot] <= d_tag;
      end
    end
  end

endmodule

// File: rtl/age_issue_queue_checker.sv
module age_issue_queue_checker #(
  parameter int DEPTH   = 16,
  parameter int SEQ_W   = 6,
  parameter int ISSUE_W = 2,
  parameter int CNT_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     commit_valid,
  input logic                     squash_valid,
  input logic [ISSUE_W-1:0]       issue_vld,
  input logic [ISSUE_W*SEQ_W-1:0] issue_seq,
  input logic [CNT_W-1:0]         free_cnt,
  input logic                     full
);

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_ord
    logic [SEQ_W-1:0] gap;
    assign gap = issue_seq[(k-1)*SEQ_W +: SEQ_W] - issue_seq[k*SEQ_W +: SEQ_W];
    a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld[k] |-> (issue_vld[k-1] && gap[SEQ_W-1]));
  end

  a_r2_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld[0] |=> !(issue_vld[0] && issue_seq[SEQ_W-1:0] == $past(issue_seq[SEQ_W-1:0])));

  a_r11_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (free_cnt >= $past(free_cnt) || $past(free_cnt) - free_cnt == CNT_W'(1)));

  a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !commit_valid && !squash_valid) |=> free_cnt == '0);

  a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH));

endmodule

bind age_issue_queue age_issue_queue_checker #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .squash_valid(squash_valid),
  .issue_vld(issue_vld), .issue_seq(issue_seq), .free_cnt(free_cnt), .full(full)
);

// File: tb/age_issue_queue_tb.sv
module age_issue_queue_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       ins_valid, ins_s0_use, ins_s0_fp, ins_s1_use, ins_s1_fp, ins_d_use, ins_d_fp, ins_nonspec;
  logic [5:0] ins_seq, ins_s0_idx, ins_s1_idx, ins_d_idx, wake_idx, rel_seq, commit_seq, squash_seq;
  logic [1:0] ins_cls;
  logic       wake_valid, wake_fp, rel_valid, commit_valid, squash_valid;
  logic [1:0]  issue_vld;
  logic [11:0] issue_seq, issue_dst;
  logic [3:0]  issue_cls;
  logic [4:0]  free_cnt;
  logic        full;

  age_issue_queue u_dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    ins_valid = 0; ins_seq = 0; ins_cls = 0; ins_s0_use = 0; ins_s0_fp = 0; ins_s0_idx = 0;
    ins_s1_use = 0; ins_s1_fp = 0; ins_s1_idx = 0; ins_d_use = 0; ins_d_fp = 0; ins_d_idx = 0;
    ins_nonspec = 0; wake_valid = 0; wake_fp = 0; wake_idx = 0; rel_valid = 0; rel_seq = 0;
    commit_valid = 0; commit_seq = 0; squash_valid = 0; squash_seq = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; clr();
  endtask

  // src < 0: no source; dst < 0: no destination
  task automatic put(int seq, int cls, int src, bit sfp, int dst, bit dfp, bit ns);
    ins_valid = 1; ins_seq = 6'(seq); ins_cls = 2'(cls); ins_nonspec = ns;
    ins_s0_use = (src >= 0); ins_s0_fp = sfp; ins_s0_idx = 6'(src < 0 ? 0 : src);
    ins_d_use = (dst >= 0); ins_d_fp = dfp; ins_d_idx = 6'(dst < 0 ? 0 : dst);
  endtask

  task automatic wake(bit fp, int idx);
    wake_valid = 1; wake_fp = fp; wake_idx = 6'(idx);
  endtask

  task automatic commit(int seq);
    commit_valid = 1; commit_seq = 6'(seq);
  endtask

  function automatic int sq(int k);
    return int'(issue_seq[k*6 +: 6]);
  endfunction

  task automatic t_reset();
    chk("R1 free", free_cnt, 16);
    chk("R1 full", full, 0);
    chk("R1 issue", issue_vld, 0);
  endtask

  task automatic t_single();
    put(1, 1, -1, 0, 3, 0, 0); step();
    chk("R2 offered", issue_vld, 1);
    chk("R2 seq", sq(0), 1);
    chk("R3 cls", issue_cls[1:0], 1);
    chk("R11 free after insert", free_cnt, 15);
    step();
    chk("R2 once", issue_vld, 0);
    chk("R2 stays allocated", free_cnt, 15);
    commit(1); step();
    chk("R9 commit frees", free_cnt, 16);
  endtask

  task automatic t_age();
    int order [6] = '{6, 3, 8, 5, 7, 4};
    int cls   [6] = '{1, 2, 2, 3, 0, 0};
    put(2, 0, -1, 0, 10, 0, 0); step();
    chk("R2 producer", sq(0), 2);
    step();
    for (int i = 0; i < 6; i++) begin put(order[i], cls[i], 10, 0, -1, 0, 0); step(); end
    chk("R6 consumers wait", issue_vld, 0);
    chk("R11 free", free_cnt, 9);
    wake(0, 10); step();
    for (int p = 0; p < 3; p++) begin
      chk("R3 two slots", issue_vld, 3);
      chk("R3 slot0 oldest", sq(0), 3 + 2*p);
      chk("R3 slot1 next", sq(1), 4 + 2*p);
      step();
    end
    chk("R3 drained", issue_vld, 0);
    commit(8); step();
    chk("R9 commit all", free_cnt, 16);
  endtask

  task automatic t_regspace();
    put(9, 0, -1, 0, 5, 1, 0); step();
    chk("R5 flat dst", int'(issue_dst[5:0]), 45);
    put(10, 1, 5, 1, -1, 0, 0); step();
    chk("R6 fp consumer waits", issue_vld, 0);
    put(11, 2, 5, 0, -1, 0, 0); step();
    chk("R5 int5 independent", issue_vld, 1);
    chk("R5 int5 seq", sq(0), 11);
    wake(0, 5); step();
    chk("R5 int wake ignored by fp src", issue_vld, 0);
    wake(1, 5); step();
    chk("R6 fp wake", issue_vld, 1);
    chk("R6 fp wake seq", sq(0), 10);
    commit(11); step();
    chk("R9 free", free_cnt, 16);
  endtask

  task automatic t_bypass();
    put(12, 0, -1, 0, 7, 0, 0); step(); step();
    put(13, 3, 7, 0, -1, 0, 0); wake(0, 7); step();
    chk("R7 bypass issue", issue_vld, 1);
    chk("R7 bypass seq", sq(0), 13);
    commit(13); step();
  endtask

  task automatic t_nonspec();
    put(14, 0, -1, 0, -1, 0, 1); step();
    chk("R8 held", issue_vld, 0);
    step();
    chk("R8 still held", issue_vld, 0);
    rel_valid = 1; rel_seq = 20; step();
    chk("R8 wrong seq", issue_vld, 0);
    rel_valid = 1; rel_seq = 14; step();
    chk("R8 released", issue_vld, 1);
    chk("R8 seq", sq(0), 14);
    commit(14); step();
  endtask

  task automatic t_squash();
    put(15, 0, -1, 0, 20, 0, 0); step();
    for (int s = 16; s <= 18; s++) begin put(s, 1, 20, 0, -1, 0, 0); step(); end
    chk("R11 free", free_cnt, 12);
    squash_valid = 1; squash_seq = 16; step();
    chk("R10 younger removed", free_cnt, 14);
    wake(0, 20); step();
    chk("R10 survivor only", issue_vld, 1);
    chk("R10 survivor seq", sq(0), 16);
    commit(16); step();
    chk("R9 free", free_cnt, 16);
  endtask

  task automatic t_full();
    put(19, 0, -1, 0, 21, 0, 0); step();
    for (int s = 20; s <= 34; s++) begin put(s, s % 4, 21, 0, -1, 0, 0); step(); end
    chk("R11 free zero", free_cnt, 0);
    chk("R11 full", full, 1);
    put(35, 0, -1, 0, -1, 0, 0); step();
    chk("R11 ignored no issue", issue_vld, 0);
    chk("R11 ignored no slot", free_cnt, 0);
    step();
    chk("R11 ignored still no issue", issue_vld, 0);
    commit(34); step();
    chk("R9 free after full", free_cnt, 16);
    chk("R11 not full", full, 0);
  endtask

  task automatic t_wrap();
    int s [4] = '{62, 0, 63, 1};
    put(59, 0, -1, 0, 22, 0, 0); step(); step();
    for (int i = 0; i < 4; i++) begin put(s[i], i, 22, 0, -1, 0, 0); step(); end
    wake(0, 22); step();
    chk("R4 wrap slot0", sq(0), 62);
    chk("R4 wrap slot1", sq(1), 63);
    step();
    chk("R4 wrap slot0 next", sq(0), 0);
    chk("R4 wrap slot1 next", sq(1), 1);
    commit(1); step();
    chk("R9 wrap commit", free_cnt, 16);
  endtask

  initial begin
    clr();
    #22 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_single();
    t_age();
    t_regspace();
    t_bypass();
    t_nonspec();
    t_squash();
    t_full();
    t_wrap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule